// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus cycle at a time on a 16-bit bus that carries the address and then the data on the same wires. The core hands it a request made of an address, memory or I/O space, read or write, byte or word, a segment status code, or an interrupt acknowledge. The sequencer then steps through the bus states T1, T2, T3, any wait states TW and T4, and produces the address strobe, the read, write and acknowledge strobes, the transceiver enable and direction, the memory/I-O line and the byte-lane enables.

The block runs on a clock at twice the bus-state rate, so each state has a first and a second half and every strobe can change at half-state resolution. A word access to an odd address is split into two byte cycles, and the core sees a single completion. Each completion is a one-clock pulse with the assembled read data. A new request may be accepted during the first half of T4, so consecutive cycles run without an idle state between them.

Top module: `bus_cycle_seq`

## Requirements
- R1: A cycle runs T1, T2, T3, then one TW for each time `ready` is found low at the end of T3 or of a TW, then T4. The active strobe stays low for 4 + 2·W clocks, where W is the number of wait states.
- R2: `ale` is high for exactly one clock, the second half of T1. While it is high, `ad_out` carries address bits 15:0 and `as_out` carries address bits 19:16 for memory cycles or zero for I/O and acknowledge cycles.
- R3: `rd_n` (memory or I/O read), `wr_n` (memory or I/O write) and `inta_n` (acknowledge) are each low only during T2, T3 and TW of their own cycle kind, never two at once, and fall on the clock right after `ale`.
- R4: `den_n` is low from the second half of T2 to the end of the first half of T4 for reads and acknowledges (4 + 2·W clocks), and from the start of T2 to the end of the first half of T4 for writes (5 + 2·W clocks).
- R5: `mio` is 1 for memory and 0 for I/O and acknowledge; `dtr` is 1 for writes and 0 otherwise. Both are valid at `ale` and do not change while a strobe is low.
- R6: At `ale` the pair {`bhe_n`, `ad_out[0]`} is 00 for a word at an even address, 01 for a byte at an odd address, 10 for a byte at an even address; it is never 11. An acknowledge cycle drives `bhe_n` low.
- R7: From T2 to T4, `as_out` carries status: bit 3 is always 0, bit 2 follows `int_en`, bits 1:0 give the segment code `req_seg`.
- R8: A word access to an odd address A runs as two byte cycles: first at A with lanes 01 and the low data byte on the upper lane (bits 15:8), then at A+1 with lanes 10 and the high data byte on the lower lane (bits 7:0), with one completion at the end.
- R9: A byte write places the low byte of `req_wdata` on both lanes; an aligned word write places the whole word. `ad_oe` is 1 during T1 and during T2–T4 of writes, and 0 while `rd_n` or `inta_n` is low.
- R10: `done` is a one-clock pulse in the second half of the final T4. `rdata` then holds the word read, or the byte read zero-extended (taken from bits 15:8 for an odd address and 7:0 for an even one), or the full bus word for an acknowledge.
- R11: `req_ready` is 1 only while idle or in the first half of T4 of a cycle that is not the first half of a split access; a request accepted in T4 starts its T1 on the next clock, so its `ale` comes two clocks after the previous `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bus-state rate |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core offers a request |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_addr | input | 20 | Byte address |
| req_mem | input | 1 | 1 memory space, 0 I/O space |
| req_write | input | 1 | 1 write, 0 read |
| req_word | input | 1 | 1 word, 0 byte |
| req_inta | input | 1 | Interrupt acknowledge cycle |
| req_seg | input | 2 | Segment status code |
| req_wdata | input | 16 | Write data |
| int_en | input | 1 | Interrupt-enable flag shown in status |
| ready | input | 1 | Device ready, sampled at end of T3 and TW |
| ad_in | input | 16 | Data returned on the bus |
| ad_out | output | 16 | Address, then write data |
| ad_oe | output | 1 | Drive enable for `ad_out` |
| as_out | output | 4 | Upper address in T1, status afterwards |
| bhe_n | output | 1 | Upper byte lane enable, active low |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| inta_n | output | 1 | Acknowledge strobe, active low |
| den_n | output | 1 | Transceiver enable, active low |
| mio | output | 1 | Memory (1) or I/O (0) |
| dtr | output | 1 | Transmit (1) or receive (0) |
| done | output | 1 | Completion pulse |
| rdata | output | 16 | Read data at completion |

## Verification
The assertions assume `ready` is a clean synchronous level and that the core holds `int_en` steady through a cycle, since the status lines follow it live. They also assume a request stays in place until `req_ready` takes it. The stimulus drives every input on the falling clock edge. It changes `int_en` only when the sequencer has gone idle, keeps each request held until it is taken, and lowers `ready` only within a wait window counted from the strobe's fall.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;

  localparam int unsigned ADDR_W = 20;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = ADDR_W - DATA_W;
  localparam int unsigned SEG_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5
  } tstate_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              mem;
    logic              wr;
    logic              word;
    logic              inta;
    logic [SEG_W-1:0]  seg;
    logic [DATA_W-1:0] wdata;
  } cyc_req_t;

  // upper lane enable (active low) for the cycle now on the bus
  function automatic logic bhe_n_of(input logic inta, input logic word,
                                    input logic split, input logic second,
                                    input logic a0);
    if (inta)       return 1'b0;
    else if (split) return second;
    else if (word)  return 1'b0;
    else            return ~a0;
  endfunction

  // placement of write data onto the two byte lanes
  function automatic logic [DATA_W-1:0] write_lanes(input logic word,
                                                    input logic split,
                                                    input logic second,
                                                    input logic [DATA_W-1:0] w);
    logic [BYTE_W-1:0] b;
    if (!word)       b = w[BYTE_W-1:0];
    else if (!split) return w;
    else if (second) b = w[DATA_W-1:BYTE_W];
    else             b = w[BYTE_W-1:0];
    return {b, b};
  endfunction

  // merge one bus sample into the read buffer
  function automatic logic [DATA_W-1:0] merge_read(input logic [DATA_W-1:0] prev,
                                                   input logic [DATA_W-1:0] bus,
                                                   input logic inta, input logic word,
                                                   input logic split, input logic second,
                                                   input logic a0);
    if (inta)       return bus;
    else if (split) return second ? {bus[BYTE_W-1:0], prev[BYTE_W-1:0]}
                                  : {prev[DATA_W-1:BYTE_W], bus[DATA_W-1:BYTE_W]};
    else if (word)  return bus;
    else if (a0)    return {{BYTE_W{1'b0}}, bus[DATA_W-1:BYTE_W]};
    else            return {{BYTE_W{1'b0}}, bus[BYTE_W-1:0]};
  endfunction

  function automatic logic [HI_W-1:0] addr_hi(input logic mem_space,
                                              input logic [ADDR_W-1:0] a);
    return mem_space ? a[ADDR_W-1:DATA_W] : '0;
  endfunction

  function automatic logic [HI_W-1:0] status_bits(input logic ie,
                                                  input logic [SEG_W-1:0] seg);
    return {1'b0, ie, seg};
  endfunction

endpackage

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
  import bus_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    launch,
  input  logic    ready,
  output tstate_e state,
  output logic    half,
  output logic    sample_rdy,
  output logic    t4_first,
  output logic    t4_last
);

  tstate_e st_n;
  logic    half_n;

  always_comb begin
    st_n   = state;
    half_n = half;
    if (state == ST_IDLE) begin
      if (launch) begin
        st_n   = ST_T1;
        half_n = 1'b0;
      end
    end else if (!half) begin
      half_n = 1'b1;
    end else begin
      half_n = 1'b0;
      unique case (state)
        ST_T1:        st_n = ST_T2;
        ST_T2:        st_n = ST_T3;
        ST_T3, ST_TW: st_n = ready ? ST_T4 : ST_TW;
        ST_T4:        st_n = launch ? ST_T1 : ST_IDLE;
        default:      st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      half  <= 1'b0;
    end else begin
      state <= st_n;
      half  <= half_n;
    end
  end

  assign sample_rdy = half && (state == ST_T3 || state == ST_TW);
  assign t4_first   = (state == ST_T4) && !half;
  assign t4_last    = (state == ST_T4) && half;

endmodule

// File: rtl/bus_req_track.sv
module bus_req_track
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  cyc_req_t          req,
  input  logic              t4_first,
  input  logic              t4_last,
  input  logic              sample_rdy,
  input  logic              ready,
  input  logic [DATA_W-1:0] ad_in,
  output cyc_req_t          cur,
  output logic              split,
  output logic              second,
  output logic              go,
  output logic              done,
  output logic              mio,
  output logic              dtr,
  output logic [DATA_W-1:0] rbuf
);

  logic capture;
  logic final_part;
  logic step_split;

  assign capture    = sample_rdy && ready && (!cur.wr || cur.inta);
  assign final_part = !split || second;
  assign step_split = t4_first && split && !second;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      split  <= 1'b0;
      second <= 1'b0;
      go     <= 1'b0;
      done   <= 1'b0;
      mio    <= 1'b0;
      dtr    <= 1'b0;
      rbuf   <= '0;
    end else begin
      done <= t4_first && final_part;
      if (capture)
        rbuf <= merge_read(rbuf, ad_in, cur.inta, cur.word, split, second, cur.addr[0]);
      if (accept) begin
        cur    <= req;
        split  <= req.word && req.addr[0] && !req.inta;
        second <= 1'b0;
        mio    <= req.mem && !req.inta;
        dtr    <= req.wr && !req.inta;
        go     <= t4_first;
      end else if (step_split) begin
        cur.addr <= cur.addr + 1'b1;
        second   <= 1'b1;
        go       <= 1'b1;
      end else if (t4_last) begin
        go <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/bus_pin_drive.sv
module bus_pin_drive
  import bus_seq_pkg::*;
(
  input  tstate_e           state,
  input  logic              half,
  input  cyc_req_t          cur,
  input  logic              split,
  input  logic              second,
  input  logic              int_en,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [HI_W-1:0]   as_out,
  output logic              bhe_n,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic              inta_n,
  output logic              den_n
);

  logic mid;
  logic is_rd;
  logic is_wr;
  logic in_t1;
  logic t4_early;
  logic den_act;
  logic [DATA_W-1:0] wbus;

  assign mid      = (state == ST_T2) || (state == ST_T3) || (state == ST_TW);
  assign in_t1    = (state == ST_T1);
  assign t4_early = (state == ST_T4) && !half;
  assign is_rd    = !cur.wr && !cur.inta;
  assign is_wr    = cur.wr && !cur.inta;
  assign wbus     = write_lanes(cur.word, split, second, cur.wdata);

  assign ale    = in_t1 && half;
  assign rd_n   = !(mid && is_rd);
  assign wr_n   = !(mid && is_wr);
  assign inta_n = !(mid && cur.inta);

  always_comb begin
    if (is_wr)
      den_act = mid || t4_early;
    else
      den_act = ((state == ST_T2) && half) || (state == ST_T3) ||
                (state == ST_TW) || t4_early;
  end
  assign den_n = !den_act;

  assign ad_oe = in_t1 || (is_wr && (mid || state == ST_T4));

  always_comb begin
    if (in_t1)      ad_out = cur.addr[DATA_W-1:0];
    else if (ad_oe) ad_out = wbus;
    else            ad_out = '0;
  end

  always_comb begin
    if (in_t1)                  as_out = addr_hi(cur.mem && !cur.inta, cur.addr);
    else if (state == ST_IDLE)  as_out = '0;
    else                        as_out = status_bits(int_en, cur.seg);
  end

  assign bhe_n = (state == ST_IDLE) ? 1'b1
               : bhe_n_of(cur.inta, cur.word, split, second, cur.addr[0]);

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic [bus_seq_pkg::ADDR_W-1:0] req_addr,
  input  logic                        req_mem,
  input  logic                        req_write,
  input  logic                        req_word,
  input  logic                        req_inta,
  input  logic [bus_seq_pkg::SEG_W-1:0]  req_seg,
  input  logic [bus_seq_pkg::DATA_W-1:0] req_wdata,
  input  logic                        int_en,
  input  logic                        ready,
  input  logic [bus_seq_pkg::DATA_W-1:0] ad_in,
  output logic [bus_seq_pkg::DATA_W-1:0] ad_out,
  output logic                        ad_oe,
  output logic [bus_seq_pkg::HI_W-1:0]   as_out,
  output logic                        bhe_n,
  output logic                        ale,
  output logic                        rd_n,
  output logic                        wr_n,
  output logic                        inta_n,
  output logic                        den_n,
  output logic                        mio,
  output logic                        dtr,
  output logic                        done,
  output logic [bus_seq_pkg::DATA_W-1:0] rdata
);

  tstate_e  state;
  logic     half;
  logic     sample_rdy;
  logic     t4_first;
  logic     t4_last;
  logic     accept;
  logic     launch;
  logic     split;
  logic     second;
  logic     go;
  cyc_req_t req;
  cyc_req_t cur;

  assign req = '{addr: req_addr, mem: req_mem, wr: req_write, word: req_word,
                 inta: req_inta, seg: req_seg, wdata: req_wdata};

  assign req_ready = (state == ST_IDLE) || (t4_first && !(split && !second));
  assign accept    = req_valid && req_ready;
  assign launch    = ((state == ST_IDLE) && accept) || (t4_last && go);

  bus_phase_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .launch     (launch),
    .ready      (ready),
    .state      (state),
    .half       (half),
    .sample_rdy (sample_rdy),
    .t4_first   (t4_first),
    .t4_last    (t4_last)
  );

  bus_req_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req        (req),
    .t4_first   (t4_first),
    .t4_last    (t4_last),
    .sample_rdy (sample_rdy),
    .ready      (ready),
    .ad_in      (ad_in),
    .cur        (cur),
    .split      (split),
    .second     (second),
    .go         (go),
    .done       (done),
    .mio        (mio),
    .dtr        (dtr),
    .rbuf       (rdata)
  );

  bus_pin_drive u_pins (
    .state  (state),
    .half   (half),
    .cur    (cur),
    .split  (split),
    .second (second),
    .int_en (int_en),
    .ad_out (ad_out),
    .ad_oe  (ad_oe),
    .as_out (as_out),
    .bhe_n  (bhe_n),
    .ale    (ale),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .inta_n (inta_n),
    .den_n  (den_n)
  );

endmodule

// File: rtl/bus_seq_chk.sv
module bus_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic        sample_rdy,
  input logic        req_ready,
  input logic        ale,
  input logic        rd_n,
  input logic        wr_n,
  input logic        inta_n,
  input logic        den_n,
  input logic        mio,
  input logic        dtr,
  input logic        bhe_n,
  input logic [15:0] ad_out,
  input logic [3:0]  as_out,
  input logic        done
);

  logic any_strobe;
  assign any_strobe = !rd_n || !wr_n || !inta_n;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_rdy && !ready |=> ($stable(rd_n) && $stable(wr_n) && $stable(inta_n))); // R1
  AST_READY_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    sample_rdy && ready |=> (rd_n && wr_n && inta_n)); // R1
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rd_n) || $fell(wr_n) || $fell(inta_n)) |-> $past(ale)); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({~rd_n, ~wr_n, ~inta_n})); // R3
  AST_DEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> !den_n); // R4
  AST_DEN_READ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> den_n); // R4
  AST_DEN_READ_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && $past(!rd_n)) |-> !den_n); // R4
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |=> ($stable(mio) && $stable(dtr))); // R5
  AST_LANE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !(bhe_n && ad_out[0])); // R6
  AST_S6_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    any_strobe |-> !as_out[3]); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_NO_ACCEPT_MID: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !any_strobe); // R11

endmodule

bind bus_cycle_seq bus_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .sample_rdy (sample_rdy),
  .req_ready  (req_ready),
  .ale        (ale),
  .rd_n       (rd_n),
  .wr_n       (wr_n),
  .inta_n     (inta_n),
  .den_n      (den_n),
  .mio        (mio),
  .dtr        (dtr),
  .bhe_n      (bhe_n),
  .ad_out     (ad_out),
  .as_out     (as_out),
  .done       (done)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_mem = 1'b0;
  logic        req_write = 1'b0;
  logic        req_word = 1'b0;
  logic        req_inta = 1'b0;
  logic [1:0]  req_seg = '0;
  logic [15:0] req_wdata = '0;
  logic        int_en = 1'b0;
  logic        ready = 1'b1;
  logic [15:0] ad_in = '0;
  logic [15:0] ad_out;
  logic        ad_oe;
  logic [3:0]  as_out;
  logic        bhe_n, ale, rd_n, wr_n, inta_n, den_n, mio, dtr, done;
  logic [15:0] rdata;

  always #2.5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_mem(req_mem), .req_write(req_write),
    .req_word(req_word), .req_inta(req_inta), .req_seg(req_seg),
    .req_wdata(req_wdata), .int_en(int_en), .ready(ready), .ad_in(ad_in),
    .ad_out(ad_out), .ad_oe(ad_oe), .as_out(as_out), .bhe_n(bhe_n),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .inta_n(inta_n), .den_n(den_n),
    .mio(mio), .dtr(dtr), .done(done), .rdata(rdata)
  );

  typedef struct {
    logic [19:0] addr;
    logic [1:0]  lanes;
    logic        mio, dtr, wr, inta;
    logic [3:0]  hi, stat;
    int          slen, dlen, w;
  } cyc_t;
  typedef struct { logic rd; logic [15:0] val; } res_t;

  cyc_t cq[$];
  res_t dq[$];
  cyc_t cur_it;
  res_t res_it;

  logic [7:0] ref_mem[256], ref_io[256], bus_mem[256], bus_io[256];
  logic [7:0] vec_tb = 8'h4C;
  int total = 0, bad = 0, cyc = 0, last_done = -100, b2b_hits = 0;
  int lowc = 0, denc = 0;
  logic [7:0]  lat_a;
  logic        lat_bhe, lat_a0;
  logic [15:0] wlast;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // driver: push expected bus cycles and result, then hand the request over
  task automatic issue(input logic mem, input logic wr, input logic word,
                       input logic inta, input logic [19:0] a,
                       input logic [15:0] wd, input logic [1:0] seg, input int w);
    int   parts;
    cyc_t it;
    res_t r;
    logic [7:0] ia, ib;
    parts = (word && a[0] && !inta) ? 2 : 1;
    for (int k = 0; k < parts; k++) begin
      it.addr = (k == 1) ? a + 20'd1 : a;
      if (inta)           it.lanes = {1'b0, a[0]};
      else if (parts == 2) it.lanes = (k == 1) ? 2'b10 : 2'b01;
      else if (word)      it.lanes = 2'b00;
      else                it.lanes = a[0] ? 2'b01 : 2'b10;
      it.mio  = mem && !inta;
      it.dtr  = wr && !inta;
      it.wr   = wr && !inta;
      it.inta = inta;
      it.hi   = it.mio ? it.addr[19:16] : 4'h0;
      it.stat = {1'b0, int_en, seg};
      it.slen = 4 + 2 * w;
      it.dlen = (it.wr ? 5 : 4) + 2 * w;
      it.w    = w;
      cq.push_back(it);
    end
    ia = a[7:0];
    ib = a[7:0] + 8'd1;
    r.rd = !wr || inta;
    if (inta)      r.val = {8'h00, vec_tb};
    else if (mem)  r.val = word ? {ref_mem[ib], ref_mem[ia]} : {8'h00, ref_mem[ia]};
    else           r.val = word ? {ref_io[ib], ref_io[ia]} : {8'h00, ref_io[ia]};
    if (wr && !inta) begin
      if (mem) begin ref_mem[ia] = wd[7:0]; if (word) ref_mem[ib] = wd[15:8]; end
      else     begin ref_io[ia]  = wd[7:0]; if (word) ref_io[ib]  = wd[15:8]; end
    end
    dq.push_back(r);
    req_addr = a; req_mem = mem; req_write = wr; req_word = word;
    req_inta = inta; req_wdata = wd; req_seg = seg; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (cq.size() != 0 || dq.size() != 0 || !req_ready);
    repeat (3) @(negedge clk);
  endtask

  // monitor: bus model and scoreboard compare, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
    if (rst_n) begin
      if (ale) begin
        if (cq.size() == 0) chk("R2 unexpected ale", 1, 0);
        else begin
          cur_it = cq.pop_front();
          if (cyc - last_done == 2) b2b_hits++;
          chk("R6 lanes", {bhe_n, ad_out[0]}, cur_it.lanes);
          chk("R2 address low", ad_out, cur_it.addr[15:0]);
          chk("R2 address high", as_out, cur_it.hi);
          chk("R5 mio", mio, cur_it.mio);
          chk("R5 dtr", dtr, cur_it.dtr);
          lat_a = ad_out[7:0]; lat_bhe = bhe_n; lat_a0 = ad_out[0];
        end
      end
      if (!rd_n || !wr_n || !inta_n) begin
        lowc++;
        if (lowc == 1) begin
          chk("R3 strobe kind", {~rd_n, ~wr_n, ~inta_n},
              {!cur_it.wr && !cur_it.inta, cur_it.wr, cur_it.inta});
          chk("R7 status", as_out, cur_it.stat);
          chk("R9 drive enable", ad_oe, cur_it.wr);
          chk("R11 not ready mid-cycle", req_ready, 0);
        end
        if (cur_it.inta)     ad_in = {8'h00, vec_tb};
        else if (cur_it.mio) ad_in = {bus_mem[{lat_a[7:1], 1'b1}], bus_mem[{lat_a[7:1], 1'b0}]};
        else                 ad_in = {bus_io[{lat_a[7:1], 1'b1}], bus_io[{lat_a[7:1], 1'b0}]};
        wlast = ad_out;
        ready = (lowc >= 4 + 2 * cur_it.w);
      end else if (lowc > 0) begin
        chk("R1 strobe length", lowc, cur_it.slen);
        if (cur_it.wr) begin
          if (cur_it.mio) begin
            if (!lat_bhe) bus_mem[{lat_a[7:1], 1'b1}] = wlast[15:8];
            if (!lat_a0)  bus_mem[{lat_a[7:1], 1'b0}] = wlast[7:0];
          end else begin
            if (!lat_bhe) bus_io[{lat_a[7:1], 1'b1}] = wlast[15:8];
            if (!lat_a0)  bus_io[{lat_a[7:1], 1'b0}] = wlast[7:0];
          end
        end
        lowc = 0;
        ready = 1'b1;
      end
      if (!den_n) denc++;
      else if (denc > 0) begin
        chk("R4 den length", denc, cur_it.dlen);
        denc = 0;
      end
      if (done) begin
        last_done = cyc;
        if (dq.size() == 0) chk("R10 unexpected done", 1, 0);
        else begin
          res_it = dq.pop_front();
          if (res_it.rd) chk("R10 read data", rdata, res_it.val);
        end
      end
    end
  end

  initial begin
    int hits0;
    for (int i = 0; i < 256; i++) begin
      ref_mem[i] = 8'(i * 7 + 3); bus_mem[i] = 8'(i * 7 + 3);
      ref_io[i]  = 8'(i * 5 + 1); bus_io[i]  = 8'(i * 5 + 1);
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset ready", req_ready, 1);
    chk("R3 reset strobes", {rd_n, wr_n, inta_n, den_n}, 4'hF);
    chk("R2 reset ale", ale, 0);
    chk("R10 reset done", done, 0);
    chk("R6 reset bhe", bhe_n, 1);

    // aligned words and bytes, no wait states (R1 R8 R9 R10)
    issue(1, 0, 1, 0, 20'hA3010, 16'h0, 2'b11, 0);
    issue(1, 1, 1, 0, 20'hA3010, 16'hBEEF, 2'b11, 0);
    issue(1, 0, 1, 0, 20'hA3010, 16'h0, 2'b11, 0);
    wait_idle();

    // byte writes and reads with wait states (R1 R4 R6)
    int_en = 1'b1;
    issue(1, 1, 0, 0, 20'h52021, 16'h7711, 2'b01, 1);
    issue(1, 1, 0, 0, 20'h52022, 16'h7722, 2'b00, 2);
    issue(1, 0, 0, 0, 20'h52021, 16'h0, 2'b01, 2);
    issue(1, 0, 0, 0, 20'h52022, 16'h0, 2'b10, 0);
    wait_idle();

    // I/O space, upper address lines forced to zero (R2 R5)
    int_en = 1'b0;
    issue(0, 1, 1, 0, 20'hF0040, 16'h1234, 2'b10, 0);
    issue(0, 0, 1, 0, 20'hF0040, 16'h0, 2'b10, 1);
    issue(0, 0, 0, 0, 20'hF0045, 16'h0, 2'b10, 0);
    wait_idle();

    // odd word split into two byte cycles (R8)
    issue(1, 1, 1, 0, 20'h6107F, 16'hC0DE, 2'b00, 0);
    issue(1, 0, 1, 0, 20'h6107F, 16'h0, 2'b00, 1);
    issue(1, 0, 1, 0, 20'h610FF, 16'h0, 2'b11, 0);
    wait_idle();

    // interrupt acknowledge (R3 R6 R10)
    vec_tb = 8'h9A;
    issue(0, 0, 0, 1, 20'h00000, 16'h0, 2'b10, 1);
    wait_idle();

    // back-to-back acceptance during T4 (R11)
    hits0 = b2b_hits;
    issue(1, 0, 1, 0, 20'h11020, 16'h0, 2'b11, 0);
    issue(1, 0, 0, 0, 20'h11031, 16'h0, 2'b11, 0);
    wait_idle();
    chk("R11 back-to-back start", b2b_hits - hits0, 1);

    chk("R10 results outstanding", dq.size(), 0);
    chk("R1 cycles outstanding", cq.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule